// File: doc/BRIEF.md
# I2C Register Slave with Decrementing Read Pointer

This block is a 7-bit-address I2C target that gives a host controller access to a byte-wide register file on the same chip. It watches the open-drain SCL and SDA lines after a two-flop synchroniser. It detects start, repeated start and stop conditions. It acknowledges its own device address and drives SDA only through an output-enable, with the line pulled low when the enable is set. The upper six bits of the device address come from a configuration register outside the block. The lowest bit comes from a strap pin, so one part can answer at either of two adjacent addresses.

A write transfer first loads an internal register pointer. Any further bytes in the same transfer are written to the register the pointer selects, and the pointer stays where it is. A read transfer returns the register at the pointer. After each byte is fetched, the pointer steps down by one, even when the host reads only a single byte. Inside the window of sample-output registers (0Ch to 11h), a step from the bottom of the window goes back to its top. A host can therefore read all six output bytes as one coherent burst. Loading the pointer with any address inside that window raises a one-cycle refresh pulse, which tells the sample registers to capture fresh data. A disable input makes the engine ignore the bus completely.

Top module: `i2c_decr_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, reg_wr_o, reg_rd_o and refresh_o are 0, and reg_addr_o is 00h.
- R2: The block acknowledges an address byte (SDA low on the ninth clock) when address bits 7:1 equal {dev_hi_i, addr_lsb_i}. Bit 0 of the address byte selects the direction: 0 is write, 1 is read.
- R3: A non-matching address byte gets no acknowledge. Every later byte until the next start condition gets no acknowledge and has no effect on the pointer or the registers.
- R4: In a write transfer, the first byte after the address is acknowledged and becomes the pointer, visible on reg_addr_o.
- R5: Each further byte in a write transfer is acknowledged and written with a one-cycle reg_wr_o pulse to the register at the pointer. The pointer does not change.
- R6: A read transfer shifts out the register at the pointer, MSB first. SDA changes only while SCL is low.
- R7: Every byte fetched for a read (one reg_rd_o pulse) decrements the pointer by one, including a single-byte read.
- R8: When a byte is fetched at pointer 0Ch, the pointer next holds 11h.
- R9: A repeated start begins a new address phase without a stop. A stop returns the engine to idle.
- R10: While if_dis_i is 1, the block never drives SDA, never acknowledges and never changes the pointer or the registers.
- R11: refresh_o pulses for one cycle exactly when the pointer is loaded by a write with a value from 0Ch to 11h.
- R12: After the host answers a read byte with NACK, the block fetches no further byte and leaves SDA released until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_lsb_i | input | 1 | Strap pin giving device address bit 0 |
| dev_hi_i | input | 6 | Device address bits 6:1 from configuration register |
| if_dis_i | input | 1 | Interface disable: bus ignored when 1 |
| reg_addr_o | output | AW | Register pointer / register file address |
| reg_rd_o | output | 1 | One-cycle pulse: byte fetched from reg_rdata_i |
| reg_rdata_i | input | 8 | Read data of the addressed register (combinational) |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| refresh_o | output | 1 | Pulse: pointer loaded inside the output-register window |

## Verification
The assertions assume the host obeys the bus rules. The host moves SDA only while SCL is low, except when it makes a start or a stop. It issues starts and stops only while the block is not pulling SDA low, it holds every SCL phase longer than the synchroniser latency, and it changes if_dis_i only while the bus is idle. The bench's host model keeps SCL phases six clocks long. It changes SDA only after a full phase with SCL low, and it releases SDA before every acknowledge slot and every read byte. The stimulus sweeps all 128 address bytes for both strap levels, pointer loads on both sides of the output window, and reads that cross the wrap point.

// File: rtl/i2c_dec_pkg.sv
package i2c_dec_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_W,
    ST_TX,
    ST_MACK
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchronising flops plus one history flop per line
  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign scl_old   = scl_p[STAGES];
  assign sda_s     = sda_p[STAGES-1];
  assign sda_old   = sda_p[STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_ptr_step.sv
module i2c_ptr_step #(
  parameter int AW = 8,
  parameter logic [AW-1:0] WIN_LO = 8'h0C,
  parameter logic [AW-1:0] WIN_HI = 8'h11
) (
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] ptr_dec_o,
  input  logic [AW-1:0] load_i,
  output logic          load_in_win_o
);
  // downward step, bottom of the output window folds back to its top
  assign ptr_dec_o     = (ptr_i == WIN_LO) ? WIN_HI : ptr_i - AW'(1);
  assign load_in_win_o = (load_i >= WIN_LO) && (load_i <= WIN_HI);
endmodule

// File: rtl/i2c_decr_slave.sv
module i2c_decr_slave
  import i2c_dec_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] WIN_LO = 8'h0C,
  parameter logic [AW-1:0] WIN_HI = 8'h11,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          addr_lsb_i,
  input  logic [5:0]    dev_hi_i,
  input  logic          if_dis_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_rd_o,
  input  logic [7:0]    reg_rdata_i,
  output logic          reg_wr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          refresh_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_e            st, st_n;
  logic [CW-1:0]      cnt, cnt_n;
  logic [BYTE_W-1:0]  shreg, shreg_n, txb, txb_n;
  logic               full, full_n, rw, rw_n, ptr_ph, ptr_ph_n, acked, acked_n;
  logic [AW-1:0]      ptr, ptr_n, ptr_dec;
  logic               win_hit, wr_s, rd_s, rf_s;
  logic [6:0]         dev_addr;

  assign dev_addr = {dev_hi_i, addr_lsb_i};

  i2c_ptr_step #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_step (
    .ptr_i(ptr), .ptr_dec_o(ptr_dec),
    .load_i(AW'(shreg)), .load_in_win_o(win_hit)
  );

  // next-state logic
  always_comb begin
    st_n = st; cnt_n = cnt; shreg_n = shreg; txb_n = txb;
    full_n = full; rw_n = rw; ptr_ph_n = ptr_ph; acked_n = acked;
    ptr_n = ptr; wr_s = 1'b0; rd_s = 1'b0; rf_s = 1'b0;
    if (if_dis_i) begin
      st_n = ST_IDLE; full_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; full_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; full_n = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_RX: begin
          if (scl_rise && !full) begin
            shreg_n = {shreg[BYTE_W-2:0], sda_s};
            cnt_n   = cnt + CW'(1);
            if (cnt == LAST_BIT) full_n = 1'b1;
          end else if (scl_fall && full) begin
            full_n = 1'b0;
            cnt_n  = '0;
            if (st == ST_ADDR) begin
              if (shreg[7:1] == dev_addr) begin
                rw_n = shreg[0]; ptr_ph_n = ~shreg[0]; st_n = ST_ACK_A;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              st_n = ST_ACK_W;
              if (ptr_ph) begin
                ptr_n = AW'(shreg); ptr_ph_n = 1'b0; rf_s = win_hit;
              end else begin
                wr_s = 1'b1;
              end
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            if (rw) begin
              st_n = ST_TX; txb_n = reg_rdata_i; rd_s = 1'b1;
              ptr_n = ptr_dec; cnt_n = '0;
            end else begin
              st_n = ST_RX;
            end
          end
        end
        ST_ACK_W: if (scl_fall) st_n = ST_RX;
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              st_n = ST_MACK; cnt_n = '0;
            end else begin
              txb_n = {txb[BYTE_W-2:0], 1'b0}; cnt_n = cnt + CW'(1);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            acked_n = ~sda_s;
          end else if (scl_fall) begin
            if (acked) begin
              st_n = ST_TX; txb_n = reg_rdata_i; rd_s = 1'b1;
              ptr_n = ptr_dec; cnt_n = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st <= ST_IDLE; cnt <= '0; shreg <= '0; txb <= '0; full <= 1'b0;
      rw <= 1'b0; ptr_ph <= 1'b0; acked <= 1'b0; ptr <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; shreg <= shreg_n; txb <= txb_n; full <= full_n;
      rw <= rw_n; ptr_ph <= ptr_ph_n; acked <= acked_n; ptr <= ptr_n;
    end
  end

  assign sda_oe_o    = (st == ST_ACK_A) || (st == ST_ACK_W) ||
                       ((st == ST_TX) && !txb[BYTE_W-1]);
  assign reg_addr_o  = ptr;
  assign reg_rd_o    = rd_s;
  assign reg_wr_o    = wr_s;
  assign reg_wdata_o = shreg;
  assign refresh_o   = rf_s;
endmodule

// File: rtl/i2c_decr_slave_chk.sv
module i2c_decr_slave_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] WIN_LO = 8'h0C,
  parameter logic [AW-1:0] WIN_HI = 8'h11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          if_dis_i,
  input logic          sda_oe_o,
  input logic [AW-1:0] reg_addr_o,
  input logic          reg_rd_o,
  input logic          reg_wr_o,
  input logic          refresh_o
);
  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    if_dis_i |=> !sda_oe_o);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_o, reg_rd_o, refresh_o}));

  assert_write_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (!reg_wr_o && reg_addr_o == $past(reg_addr_o)));

  assert_ptr_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_o && reg_addr_o != WIN_LO) |=> (reg_addr_o + AW'(1) == $past(reg_addr_o)));

  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_o && reg_addr_o == WIN_LO) |=> (reg_addr_o == WIN_HI));

  assert_refresh_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_o |=> (reg_addr_o >= WIN_LO && reg_addr_o <= WIN_HI && !refresh_o));

  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_decr_slave i2c_decr_slave_chk #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .if_dis_i(if_dis_i),
  .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o), .reg_rd_o(reg_rd_o),
  .reg_wr_o(reg_wr_o), .refresh_o(refresh_o)
);

// File: tb/sim_i2c_decr_slave.sv
`timescale 1ns/1ps
module sim_i2c_decr_slave;
  localparam int HP = 6;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl_m, sda_m, sda_line, sda_oe, strap, if_dis;
  logic [5:0] dev_hi;
  logic [7:0] reg_addr, reg_rdata, reg_wdata;
  logic reg_rd, reg_wr, refresh;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int nchk = 0, nfail = 0, rf_cnt = 0, rd_cnt = 0;
  bit done = 1'b0;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_decr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_lsb_i(strap), .dev_hi_i(dev_hi), .if_dis_i(if_dis),
    .reg_addr_o(reg_addr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata),
    .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .refresh_o(refresh)
  );

  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (refresh) rf_cnt <= rf_cnt + 1;
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  function automatic logic [7:0] stepf(input logic [7:0] p);
    return (p == 8'h0C) ? 8'h11 : p - 8'd1;
  endfunction

  task automatic hp();
    repeat (HP) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    ack = ~sda_line;
    scl_m = 1'b0; hp();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1; hp(); b[i] = sda_line; scl_m = 1'b0;
    end
    hp(); sda_m = ~mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] aw();
    return {dev_hi, strap, 1'b0};
  endfunction
  function automatic logic [7:0] ar();
    return {dev_hi, strap, 1'b1};
  endfunction

  task automatic set_ptr(input logic [7:0] p, output logic a0, output logic a1);
    bus_start(); send_byte(aw(), a0); send_byte(p, a1); bus_stop();
  endtask

  task automatic read_one(output logic [7:0] d, output logic a);
    bus_start(); send_byte(ar(), a); recv_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      finish_run();
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d, d2, q;
    int rf0, rd0;
    bit low_seen;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0; if_dis = 1'b0; dev_hi = 6'h0F;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    hp();
    // R1 reset state
    check("R1 sda_oe", sda_oe, 0);
    check("R1 reg_wr", reg_wr, 0);
    check("R1 reg_rd", reg_rd, 0);
    check("R1 refresh", refresh, 0);
    check("R1 reg_addr", reg_addr, 8'h00);

    // R4 / R11 pointer loads across the window edges
    for (int p = 8'h08; p <= 8'h14; p++) begin
      rf0 = rf_cnt;
      set_ptr(8'(p), a0, a1);
      check("R2 addr ack", a0, 1);
      check("R4 ptr ack", a1, 1);
      check("R4 ptr value", reg_addr, 8'(p));
      check("R11 refresh count", rf_cnt - rf0, (p >= 8'h0C && p <= 8'h11) ? 1 : 0);
    end

    // R5 data writes, pointer stays
    bus_start(); send_byte(aw(), a0); send_byte(8'h05, a1); send_byte(8'h5A, a2);
    check("R5 ptr after write", reg_addr, 8'h05);
    send_byte(8'hA5, a3); bus_stop();
    exp_mem[5] = 8'hA5;
    check("R5 data ack", a2 & a3, 1);
    check("R5 ptr unchanged", reg_addr, 8'h05);
    read_one(d, a0);
    check("R5 written value", d, exp_mem[5]);

    // R6 / R7 / R8 / R9 single reads via repeated start
    for (int k = 0; k < 9; k++) begin
      logic [7:0] p;
      p = (k < 6) ? 8'(8'h0C + k) : ((k == 6) ? 8'h05 : ((k == 7) ? 8'h20 : 8'h01));
      bus_start(); send_byte(aw(), a0); send_byte(p, a1);
      bus_start(); send_byte(ar(), a2); recv_byte(1'b0, d); bus_stop();
      check("R9 ack after repeated start", a2, 1);
      check("R6 read data", d, exp_mem[p]);
      check("R7 ptr after single read", reg_addr, stepf(p));
      read_one(d2, a3);
      check("R7 next single read", d2, exp_mem[stepf(p)]);
      check("R8 ptr after two reads", reg_addr, stepf(stepf(p)));
    end

    // R8 burst across the wrap, then R12 after NACK
    set_ptr(8'h11, a0, a1);
    q = 8'h11;
    bus_start(); send_byte(ar(), a0);
    for (int k = 0; k < 8; k++) begin
      recv_byte(k < 7, d);
      check("R8 burst data", d, exp_mem[q]);
      q = stepf(q);
    end
    check("R8 ptr after burst", reg_addr, q);
    rd0 = rd_cnt;
    low_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      hp(); scl_m = 1'b1; hp(); if (!sda_line) low_seen = 1'b1; scl_m = 1'b0;
    end
    hp();
    check("R12 sda released after nack", low_seen, 0);
    check("R12 no fetch after nack", rd_cnt - rd0, 0);
    bus_stop();

    // R2 other configuration value
    dev_hi = 6'h2A; strap = 1'b1;
    set_ptr(8'h03, a0, a1);
    check("R2 ack with other hi bits", a0, 1);
    check("R4 ptr with other hi bits", reg_addr, 8'h03);
    dev_hi = 6'h0F;

    // R2 / R3 sweep of every address byte for both strap levels
    for (int s = 0; s < 2; s++) begin
      strap = s[0];
      for (int a = 0; a < 128; a++) begin
        bus_start(); send_byte({7'(a), 1'b0}, a0); bus_stop();
        check("R3 address sweep ack", a0, (a == {6'h0F, s[0]}) ? 1 : 0);
      end
    end

    // R3 bytes after a mismatch are ignored
    strap = 1'b0;
    set_ptr(8'h02, a0, a1);
    bus_start(); send_byte({7'h1F, 1'b0}, a0); send_byte(8'h07, a1); send_byte(8'h99, a2); bus_stop();
    check("R3 mismatch nack", a0, 0);
    check("R3 later byte nack", a1 | a2, 0);
    check("R3 ptr untouched", reg_addr, 8'h02);
    read_one(d, a0);
    check("R3 register untouched", d, exp_mem[2]);

    // R10 disable input
    if_dis = 1'b1;
    rf0 = rf_cnt;
    hp();
    bus_start(); send_byte(aw(), a0); send_byte(8'h0D, a1); send_byte(8'h42, a2); bus_stop();
    check("R10 no ack while disabled", a0 | a1 | a2, 0);
    check("R10 ptr untouched", reg_addr, 8'h01);
    check("R10 no refresh", rf_cnt - rf0, 0);
    if_dis = 1'b0;
    hp();
    set_ptr(8'h0D, a0, a1);
    check("R10 ack after enable", a0 & a1, 1);
    read_one(d, a0);
    check("R10 register 0Dh untouched", d, exp_mem[8'h0D]);

    done = 1'b1;
    finish_run();
  end
endmodule